// File: doc/BRIEF.md
# Legacy Wired Interrupt Request Controller

This block manages the legacy wired interrupt line of one PCI function. The device logic issues single-cycle raise and drop requests. Whether the wire may actually be driven depends on the function's command-register interrupt-disable bit and on its message-signalled interrupt enables. The block turns these inputs into one registered level request for the downstream interrupt link router. It also emits a one-cycle pulse on each rising and falling edge of that level, so the router can keep a per-link count of active sources.

A three-state machine keeps track of a request that arrives while the wire is blocked. The states are: Idle (no request outstanding), Live (request outstanding and driven) and Held (request outstanding but blocked). A request made while the wire is blocked is kept and delivered once the block is lifted. Blocking a driven line withdraws it. Unblocking puts it back, with no new request from the device.

The transitions are:
- Idle to Live on a raise while permitted.
- Idle to Held on a raise while blocked.
- Live to Idle on a drop.
- Live to Held on loss of permission.
- Held to Idle on a drop.
- Held to Live on regaining permission.

Top module: `intx_line_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `line_o`, `rise_pulse_o` and `fall_pulse_o` are 0, and the machine is in Idle.
- R2: A raise in Idle while permitted enters Live, and `line_o` is 1 after the next clock edge.
- R3: A raise in Idle while blocked enters Held with `line_o` at 0. When permission later returns, the machine enters Live and `line_o` rises with no new request.
- R4: A raise in Live or Held changes neither the state nor `line_o`.
- R5: A drop in Live enters Idle and `line_o` falls at the next edge. A drop in Held enters Idle silently, so a later return of permission does not raise `line_o`.
- R6: Loss of permission in Live drops `line_o` at the next edge and enters Held. If a drop arrives in the same cycle, the drop takes precedence and the machine goes to Idle.
- R7: Permission is `intx_dis_i == 0` and all `msg_en_i` bits 0. Bit 0 is the MSI enable and bit 1 is the MSI-X enable. Any one of these set blocks the wire.
- R8: When raise and drop are requested in the same cycle, the drop wins.
- R9: `rise_pulse_o` (respectively `fall_pulse_o`) is 1 for exactly the one cycle in which `line_o` has just gone from 0 to 1 (respectively 1 to 0). The two pulses are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_req_i | input | 1 | Device asks for the interrupt line to be asserted |
| drop_req_i | input | 1 | Device withdraws its interrupt request |
| intx_dis_i | input | 1 | Command-register interrupt-disable bit |
| msg_en_i | input | N_MSG_EN | Message-interrupt enables (bit 0 MSI, bit 1 MSI-X) |
| line_o | output | 1 | Registered level request toward the link router |
| rise_pulse_o | output | 1 | One-cycle pulse when line_o goes high |
| fall_pulse_o | output | 1 | One-cycle pulse when line_o goes low |

## Verification
The bench builds the block with the default N_MSG_EN of 2. With that setting, the disable bit, the MSI enable and the MSI-X enable can each be toggled on its own. This lets every blocking source be shown to both withdraw a Live line and keep a Held request. Walking every state through raise, drop, simultaneous raise and drop, and permission changes reaches all six transitions. It also covers the cases where nothing should change.

// File: rtl/intx_pkg.sv
package intx_pkg;

    typedef enum logic [1:0] {
        INTX_IDLE = 2'd0,
        INTX_LIVE = 2'd1,
        INTX_HELD = 2'd2
    } intx_state_e;

    typedef enum logic [1:0] {
        REQ_NONE  = 2'd0,
        REQ_RAISE = 2'd1,
        REQ_DROP  = 2'd2
    } intx_req_e;

endpackage

// File: rtl/intx_permit.sv
module intx_permit #(
    parameter int N_MSG_EN = 2
) (
    input  logic                intx_dis_i,
    input  logic [N_MSG_EN-1:0] msg_en_i,
    output logic                permit_o
);
    // R7: any blocking source withholds the wire
    always_comb begin
        permit_o = !intx_dis_i && (msg_en_i == '0);
    end
endmodule

// File: rtl/intx_req_resolve.sv
module intx_req_resolve
    import intx_pkg::*;
(
    input  logic      raise_i,
    input  logic      drop_i,
    output intx_req_e req_o
);
    // R8: a drop overrides a raise in the same cycle
    always_comb begin
        if (drop_i)
            req_o = REQ_DROP;
        else if (raise_i)
            req_o = REQ_RAISE;
        else
            req_o = REQ_NONE;
    end
endmodule

// File: rtl/intx_state_core.sv
module intx_state_core
    import intx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  intx_req_e   req_i,
    input  logic        permit_i,
    output intx_state_e state_d_o
);
    intx_state_e state_q;
    intx_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= INTX_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            INTX_IDLE: begin
                if (req_i == REQ_RAISE)
                    state_d = permit_i ? INTX_LIVE : INTX_HELD;
            end
            INTX_LIVE: begin
                if (req_i == REQ_DROP)
                    state_d = INTX_IDLE;
                else if (!permit_i)
                    state_d = INTX_HELD;
            end
            INTX_HELD: begin
                if (req_i == REQ_DROP)
                    state_d = INTX_IDLE;
                else if (permit_i)
                    state_d = INTX_LIVE;
            end
            default: state_d = INTX_IDLE;
        endcase
    end

    assign state_d_o = state_d;
endmodule

// File: rtl/intx_line_out.sv
module intx_line_out
    import intx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  intx_state_e state_d_i,
    output logic        line_o,
    output logic        rise_o,
    output logic        fall_o
);
    logic live_next;
    logic line_q;

    always_comb begin
        live_next = (state_d_i == INTX_LIVE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= 1'b0;
            rise_o <= 1'b0;
            fall_o <= 1'b0;
        end else begin
            line_q <= live_next;
            rise_o <= live_next && !line_q;
            fall_o <= !live_next && line_q;
        end
    end

    assign line_o = line_q;
endmodule

// File: rtl/intx_line_ctrl.sv
module intx_line_ctrl
    import intx_pkg::*;
#(
    parameter int N_MSG_EN = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                raise_req_i,
    input  logic                drop_req_i,
    input  logic                intx_dis_i,
    input  logic [N_MSG_EN-1:0] msg_en_i,
    output logic                line_o,
    output logic                rise_pulse_o,
    output logic                fall_pulse_o
);
    logic        permit;
    intx_req_e   req;
    intx_state_e state_d;

    intx_permit #(.N_MSG_EN(N_MSG_EN)) u_permit (
        .intx_dis_i (intx_dis_i),
        .msg_en_i   (msg_en_i),
        .permit_o   (permit)
    );

    intx_req_resolve u_req (
        .raise_i (raise_req_i),
        .drop_i  (drop_req_i),
        .req_o   (req)
    );

    intx_state_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req),
        .permit_i  (permit),
        .state_d_o (state_d)
    );

    intx_line_out u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_d_i (state_d),
        .line_o    (line_o),
        .rise_o    (rise_pulse_o),
        .fall_o    (fall_pulse_o)
    );
endmodule

// File: rtl/intx_line_ctrl_chk.sv
module intx_line_ctrl_chk #(
    parameter int N_MSG_EN = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                raise_req_i,
    input logic                drop_req_i,
    input logic                intx_dis_i,
    input logic [N_MSG_EN-1:0] msg_en_i,
    input logic                line_o,
    input logic                rise_pulse_o,
    input logic                fall_pulse_o
);
    logic ok_in;
    assign ok_in = !intx_dis_i && (msg_en_i == '0);

    p_rise_needs_permit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_o) |-> $past(ok_in));

    p_hold_on_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        line_o && ok_in && !drop_req_i |=> line_o);

    p_drop_lowers_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drop_req_i |=> !line_o);

    p_block_lowers_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ok_in |=> !line_o);

    p_rise_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse_o |-> line_o && !$past(line_o));

    p_fall_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fall_pulse_o |-> !line_o && $past(line_o));

    p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_pulse_o && fall_pulse_o));
endmodule

bind intx_line_ctrl intx_line_ctrl_chk #(.N_MSG_EN(N_MSG_EN)) chk_i (.*);

// File: tb/intx_line_ctrl_tb_top.sv
module intx_line_ctrl_tb_top;
    localparam int N_MSG_EN = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic raise_req = 1'b0;
    logic drop_req = 1'b0;
    logic intx_dis = 1'b0;
    logic [N_MSG_EN-1:0] msg_en = '0;
    logic line, rise_p, fall_p;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [2:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    intx_line_ctrl #(.N_MSG_EN(N_MSG_EN)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .raise_req_i  (raise_req),
        .drop_req_i   (drop_req),
        .intx_dis_i   (intx_dis),
        .msg_en_i     (msg_en),
        .line_o       (line),
        .rise_pulse_o (rise_p),
        .fall_pulse_o (fall_p)
    );

    task automatic compare(input logic [2:0] exp, input string tag);
        checks++;
        if ({line, rise_p, fall_p} !== exp) begin
            errors++;
            $display("FAIL %s: line/rise/fall actual=%b expected=%b", tag,
                     {line, rise_p, fall_p}, exp);
        end
    endtask

    // Driver: one cycle of stimulus plus the outputs expected after its edge
    task automatic step(input logic r, input logic d, input logic dis,
                        input logic [N_MSG_EN-1:0] me, input logic [2:0] exp,
                        input string tag);
        @(negedge clk);
        raise_req = r;
        drop_req  = d;
        intx_dis  = dis;
        msg_en    = me;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare shortly after each edge that consumes a driven cycle
    initial begin
        forever begin
            @(posedge clk);
            if (exp_q.size() != 0) begin
                logic [2:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                #2;
                compare(e, t);
            end
        end
    end

    initial begin
        raise_req = 1'b1;             // R1: request during reset ignored
        repeat (3) @(posedge clk);
        #2 compare(3'b000, "R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        raise_req = 1'b0;
        step(0, 0, 0, 2'b00, 3'b000, "R1 after reset");
        step(1, 0, 0, 2'b00, 3'b110, "R2 raise permitted");
        step(0, 0, 0, 2'b00, 3'b100, "R9 rise pulse one cycle");
        step(1, 0, 0, 2'b00, 3'b100, "R4 raise in Live");
        step(0, 1, 0, 2'b00, 3'b001, "R5 drop in Live");
        step(0, 0, 0, 2'b00, 3'b000, "R9 fall pulse one cycle");
        step(1, 0, 1, 2'b00, 3'b000, "R3 raise blocked to Held");
        step(1, 0, 1, 2'b00, 3'b000, "R4 raise in Held");
        step(0, 0, 1, 2'b00, 3'b000, "R3 Held stays low");
        step(0, 0, 0, 2'b00, 3'b110, "R3 unblock delivers");
        step(0, 0, 0, 2'b01, 3'b001, "R7 MSI blocks Live");
        step(0, 0, 0, 2'b00, 3'b110, "R6 restore after MSI");
        step(0, 0, 0, 2'b10, 3'b001, "R7 MSI-X blocks Live");
        step(0, 1, 0, 2'b10, 3'b000, "R5 drop in Held");
        step(0, 0, 0, 2'b00, 3'b000, "R5 no delivery after Held drop");
        step(1, 1, 0, 2'b00, 3'b000, "R8 both in Idle");
        step(0, 0, 0, 2'b00, 3'b000, "R8 Idle kept");
        step(1, 0, 0, 2'b00, 3'b110, "R2 raise again");
        step(1, 1, 0, 2'b00, 3'b001, "R8 both in Live");
        step(1, 0, 0, 2'b11, 3'b000, "R7 both enables block raise");
        step(1, 1, 0, 2'b11, 3'b000, "R8 both in Held");
        step(0, 0, 0, 2'b00, 3'b000, "R8 Held cleared");
        step(1, 0, 0, 2'b00, 3'b110, "R2 raise third");
        step(1, 0, 1, 2'b00, 3'b001, "R6 disable in Live with raise");
        step(0, 1, 0, 2'b00, 3'b000, "R6 drop wins over unblock");
        step(0, 0, 0, 2'b00, 3'b000, "R5 stays Idle");
        step(1, 0, 0, 2'b00, 3'b110, "R2 raise fourth");
        step(0, 1, 1, 2'b00, 3'b001, "R6 drop with block goes Idle");
        step(0, 0, 0, 2'b00, 3'b000, "R6 no restore after drop");
        step(0, 0, 0, 2'b00, 3'b000, "R1 idle tail");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule